// File: doc/BRIEF.md
# Per-Link Two-Level Interrupt Register Bank

This block collects the interrupt events of one communication link and turns them into one interrupt request. The first level is a status register of event latches plus one summary bit. Each event latch is set by a single-cycle pulse from the link logic. Examples are the start and the end of a loss of cell delineation on the receive side. The summary bit does not latch. It reflects the second level, which is a set of sticky overflow latches fed by counter-wrap pulses and by a receive FIFO overflow pulse.

Software reaches four registers through a small read/write port: the status register, its enable register, the overflow status register and the overflow enable register. A latch clears only when software writes 0 to its bit. Writing 1 leaves it unchanged, and reading leaves it unchanged. The interrupt request is a registered OR of every enabled first-level bit. A service routine can mask one source while it handles that source elsewhere, and re-enable it later.

Top module: `irq_link_bank`

## Requirements
- R1: Event pulses set status latches as follows. `ev_lcd_start` sets bit 1 and `ev_lcd_end` sets bit 9. `ev_misc[4:0]` set bits 2 to 6, `ev_misc[5]` sets bit 10 and `ev_misc[6]` sets bit 11. A latch is visible in the next read after the edge that carries the pulse.
- R2: Writing a 0 bit to status (address 0) clears the matching latch among bits 1-6 and 9-11. Writing a 1 bit leaves the latch as it was. The same rule holds for the overflow status latches (address 2).
- R3: Status bit 0 reads 1 whenever any overflow latch is set and its overflow enable bit is 1. Writing 0 to status bit 0 does not change it.
- R4: Status bit 0 returns to 0 once every enabled overflow latch is cleared, or once the enables of the set latches are cleared.
- R5: Reading any register changes no latch.
- R6: Overflow status layout: bit 12 is `ovf_fifo`, bits 11:8 are `ovf_in[3:0]`, bit 7 is `ovf_tx[1]`, bit 5 is `ovf_tx[0]` and bits 3:1 are `ovf_rx[2:0]`. Each pulse sets its latch. All other bits read 0.
- R7: `irq_o` is the OR over status bits 0-6 and 9-11 of (status AND enable). It updates one clock after the status or enable change. Enable bit n lives at bit n of address 1.
- R8: When an event pulse and a clearing write hit the same latch in the same cycle, the latch ends up at 1.
- R9: Addresses are 0 status, 1 enable, 2 overflow status and 3 overflow enable, on a 16-bit data bus. Unimplemented bits and other addresses read 0. `cpu_rdata` is valid the clock after `cpu_rd` is sampled.
- R10: Reset (synchronous, active high) clears every latch, every enable, `irq_o` and `cpu_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 4 | Register address |
| cpu_wr | input | 1 | Write strobe |
| cpu_wdata | input | 16 | Write data |
| cpu_rd | input | 1 | Read strobe |
| cpu_rdata | output | 16 | Registered read data |
| ev_lcd_start | input | 1 | Pulse: loss of cell delineation begins |
| ev_lcd_end | input | 1 | Pulse: cell delineation regained |
| ev_misc | input | 7 | Pulses for the other first-level events |
| ovf_fifo | input | 1 | Pulse: receive FIFO overflow |
| ovf_in | input | 4 | Pulses: input-side counter wraps |
| ovf_tx | input | 2 | Pulses: transmit counter wraps |
| ovf_rx | input | 3 | Pulses: receive counter wraps |
| irq_o | output | 1 | Registered interrupt request |

## Verification
Two functions can fall in the same cycle: an event pulse setting a latch, and a software write of 0 clearing that same latch. The bench drives `ev_lcd_start` together with a zero write to address 0 in one cycle. It then reads status and expects bit 1 still set, which shows the set took priority over the clear. A second collision is a write of 0 to bit 0 while an enabled overflow latch is set. The bench reads bit 0 back and expects it to stay at 1.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;
  localparam int DW = 16;
  localparam int AW = 4;

  // implemented bit positions
  localparam logic [DW-1:0] STAT_LATCH_MASK = 16'h0E7E;
  localparam logic [DW-1:0] ENA_MASK        = 16'h0E7F;
  localparam logic [DW-1:0] OVF_MASK        = 16'h1FAE;

  typedef enum logic [AW-1:0] {
    A_STAT     = 4'd0,
    A_ENA      = 4'd1,
    A_OVF_STAT = 4'd2,
    A_OVF_ENA  = 4'd3
  } reg_addr_e;
endpackage

// File: rtl/sticky_bank.sv
module sticky_bank #(
  parameter int W = 16,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (MASK[i]) begin : g_lat
      logic r;
      always_ff @(posedge clk) begin
        if (rst)           r <= 1'b0;
        else if (set_i[i]) r <= 1'b1;
        else if (wr_i && !wdata_i[i]) r <= 1'b0;
      end
      assign q_o[i] = r;
    end else begin : g_zero
      assign q_o[i] = 1'b0;
    end
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (|(set_i & MASK)) |=> ((q_o & $past(set_i & MASK)) == $past(set_i & MASK))); // R8
  AST_ONE_NO_CLEAR: assert property (@(posedge clk) disable iff (rst)
    wr_i |=> (($past(q_o) & $past(wdata_i) & ~q_o) == '0)); // R2
  AST_NO_WRITE_KEEPS: assert property (@(posedge clk) disable iff (rst)
    !wr_i |=> ((q_o & $past(q_o)) == $past(q_o))); // R5
endmodule

// File: rtl/mask_reg.sv
module mask_reg #(
  parameter int W = 16,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] r;
  always_ff @(posedge clk) begin
    if (rst)       r <= '0;
    else if (wr_i) r <= wdata_i & MASK;
  end
  assign q_o = r;

  AST_UNUSED_ZERO_REG: assert property (@(posedge clk) disable iff (rst)
    (q_o & ~MASK) == '0); // R9
endmodule

// File: rtl/irq_link_bank.sv
module irq_link_bank
  import irq_bank_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] cpu_addr,
  input  logic          cpu_wr,
  input  logic [DW-1:0] cpu_wdata,
  input  logic          cpu_rd,
  output logic [DW-1:0] cpu_rdata,
  input  logic          ev_lcd_start,
  input  logic          ev_lcd_end,
  input  logic [6:0]    ev_misc,
  input  logic          ovf_fifo,
  input  logic [3:0]    ovf_in,
  input  logic [1:0]    ovf_tx,
  input  logic [2:0]    ovf_rx,
  output logic          irq_o
);
  logic [DW-1:0] stat_set, ovf_set;
  logic [DW-1:0] stat_q, ena_q, ovf_q, oen_q, stat_view;
  logic          wr_stat, wr_ena, wr_ovf, wr_oen, summary;
  logic [DW-1:0] rdata_q;
  logic          irq_q;

  always_comb begin
    stat_set      = '0;
    stat_set[1]   = ev_lcd_start;
    stat_set[6:2] = ev_misc[4:0];
    stat_set[9]   = ev_lcd_end;
    stat_set[10]  = ev_misc[5];
    stat_set[11]  = ev_misc[6];
    ovf_set       = '0;
    ovf_set[12]   = ovf_fifo;
    ovf_set[11:8] = ovf_in;
    ovf_set[7]    = ovf_tx[1];
    ovf_set[5]    = ovf_tx[0];
    ovf_set[3:1]  = ovf_rx;
  end

  assign wr_stat = cpu_wr && (cpu_addr == A_STAT);
  assign wr_ena  = cpu_wr && (cpu_addr == A_ENA);
  assign wr_ovf  = cpu_wr && (cpu_addr == A_OVF_STAT);
  assign wr_oen  = cpu_wr && (cpu_addr == A_OVF_ENA);

  sticky_bank #(.W(DW), .MASK(STAT_LATCH_MASK)) u_stat (
    .clk(clk), .rst(rst), .set_i(stat_set), .wr_i(wr_stat),
    .wdata_i(cpu_wdata), .q_o(stat_q));

  sticky_bank #(.W(DW), .MASK(OVF_MASK)) u_ovf (
    .clk(clk), .rst(rst), .set_i(ovf_set), .wr_i(wr_ovf),
    .wdata_i(cpu_wdata), .q_o(ovf_q));

  mask_reg #(.W(DW), .MASK(ENA_MASK)) u_ena (
    .clk(clk), .rst(rst), .wr_i(wr_ena), .wdata_i(cpu_wdata), .q_o(ena_q));

  mask_reg #(.W(DW), .MASK(OVF_MASK)) u_oen (
    .clk(clk), .rst(rst), .wr_i(wr_oen), .wdata_i(cpu_wdata), .q_o(oen_q));

  assign summary   = |(ovf_q & oen_q);
  assign stat_view = stat_q | {{(DW-1){1'b0}}, summary};

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= |(stat_view & ena_q);
      if (cpu_rd) begin
        case (cpu_addr)
          A_STAT:     rdata_q <= stat_view;
          A_ENA:      rdata_q <= ena_q;
          A_OVF_STAT: rdata_q <= ovf_q;
          A_OVF_ENA:  rdata_q <= oen_q;
          default:    rdata_q <= '0;
        endcase
      end
    end
  end

  assign cpu_rdata = rdata_q;
  assign irq_o     = irq_q;

  AST_IRQ_NO_ENA: assert property (@(posedge clk) disable iff (rst)
    (ena_q == '0) |=> !irq_o); // R7
  AST_RD_UNUSED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && cpu_addr == A_STAT) |=> (cpu_rdata[15:12] == '0 && cpu_rdata[8:7] == '0)); // R9
  AST_SUM_MASKED: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && cpu_addr == A_STAT && (ovf_q & oen_q) == '0) |=> !cpu_rdata[0]); // R4
  AST_SUM_SET: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && cpu_addr == A_STAT && (ovf_q & oen_q) != '0) |=> cpu_rdata[0]); // R3
endmodule

// File: tb/irq_link_bank_test.sv
module irq_link_bank_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  cpu_addr = '0;
  logic        cpu_wr = 1'b0, cpu_rd = 1'b0;
  logic [15:0] cpu_wdata = '0;
  logic [15:0] cpu_rdata;
  logic        ev_lcd_start = 1'b0, ev_lcd_end = 1'b0;
  logic [6:0]  ev_misc = '0;
  logic        ovf_fifo = 1'b0;
  logic [3:0]  ovf_in = '0;
  logic [1:0]  ovf_tx = '0;
  logic [2:0]  ovf_rx = '0;
  logic        irq_o;
  int          total = 0, bad = 0;
  logic [15:0] rv;

  always #10 clk = ~clk;

  irq_link_bank uut (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
    .cpu_wdata(cpu_wdata), .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata),
    .ev_lcd_start(ev_lcd_start), .ev_lcd_end(ev_lcd_end), .ev_misc(ev_misc),
    .ovf_fifo(ovf_fifo), .ovf_in(ovf_in), .ovf_tx(ovf_tx), .ovf_rx(ovf_rx),
    .irq_o(irq_o));

  // {ovf pulse vector, overflow enable, expected status bit 0}
  localparam logic [32:0] VEC [6] = '{
    {16'h1000, 16'h1000, 1'b1},
    {16'h0100, 16'h1000, 1'b0},
    {16'h0080, 16'h0080, 1'b1},
    {16'h0020, 16'h1FAE, 1'b1},
    {16'h000E, 16'h0002, 1'b1},
    {16'hFFFF, 16'h0000, 1'b0}
  };

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    @(negedge clk); cpu_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk); cpu_addr = a; cpu_rd = 1'b1;
    @(negedge clk); cpu_rd = 1'b0; d = cpu_rdata;
  endtask

  task automatic ovf_pulse(input logic [15:0] v);
    @(negedge clk);
    ovf_fifo = v[12]; ovf_in = v[11:8]; ovf_tx = {v[7], v[5]}; ovf_rx = v[3:1];
    @(negedge clk);
    ovf_fifo = 0; ovf_in = '0; ovf_tx = '0; ovf_rx = '0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    for (int a = 0; a < 4; a++) begin
      rd(a[3:0], rv); check("R10 reset reg", rv, 16'h0000);
    end
    check("R10 reset irq", {15'b0, irq_o}, 16'h0000);

    // table walk: R6 layout, R3/R4 summary
    for (int i = 0; i < 6; i++) begin
      wr(4'd2, 16'h0000);
      wr(4'd3, VEC[i][16:1]);
      ovf_pulse(VEC[i][32:17]);
      rd(4'd2, rv); check("R6 ovf layout", rv, VEC[i][32:17] & 16'h1FAE);
      rd(4'd0, rv); check("R3 summary bit", {15'b0, rv[0]}, {15'b0, VEC[i][0]});
    end
    wr(4'd2, 16'hFFFF);
    rd(4'd2, rv); check("R2 ovf write ones keeps", rv, 16'h1FAE);
    wr(4'd2, 16'h0000); wr(4'd3, 16'h0000);

    // R1 event latches
    @(negedge clk); ev_lcd_start = 1; ev_misc = 7'h7F;
    @(negedge clk); ev_lcd_start = 0; ev_misc = '0; ev_lcd_end = 1;
    @(negedge clk); ev_lcd_end = 0;
    rd(4'd0, rv); check("R1 event latches", rv, 16'h0E7E);
    // R5 read does not clear
    rd(4'd0, rv); check("R5 reread", rv, 16'h0E7E);
    // R2 write ones no effect, selective zero clears
    wr(4'd0, 16'hFFFF);
    rd(4'd0, rv); check("R2 ones keep", rv, 16'h0E7E);
    wr(4'd0, 16'hFDFD);
    rd(4'd0, rv); check("R2 zero clears", rv, 16'h0C7C);
    wr(4'd0, 16'h0000);
    rd(4'd0, rv); check("R2 all cleared", rv, 16'h0000);

    // R3 write 0 to bit 0 no effect; R4 drop paths
    wr(4'd3, 16'h0002);
    ovf_pulse(16'h0002);
    wr(4'd0, 16'h0000);
    rd(4'd0, rv); check("R3 bit0 survives write", rv, 16'h0001);
    wr(4'd3, 16'h0000);
    rd(4'd0, rv); check("R4 mask drops bit0", rv, 16'h0000);
    wr(4'd3, 16'h0002);
    rd(4'd0, rv); check("R4 re-enable", rv, 16'h0001);
    wr(4'd2, 16'h0000);
    rd(4'd0, rv); check("R4 clear drops bit0", rv, 16'h0000);

    // R7 irq timing
    wr(4'd1, 16'h0002);
    @(negedge clk); ev_lcd_start = 1;
    @(negedge clk); ev_lcd_start = 0;
    check("R7 irq not yet", {15'b0, irq_o}, 16'h0000);
    @(negedge clk);
    check("R7 irq raised", {15'b0, irq_o}, 16'h0001);
    @(negedge clk); ev_lcd_end = 1;
    @(negedge clk); ev_lcd_end = 0;
    @(negedge clk);
    check("R7 masked source", {15'b0, irq_o}, 16'h0001);
    wr(4'd0, 16'hFFFD);
    @(negedge clk);
    check("R7 irq dropped", {15'b0, irq_o}, 16'h0000);

    // R8 set wins over clear
    @(negedge clk); ev_lcd_start = 1; cpu_addr = 4'd0; cpu_wdata = 16'h0000; cpu_wr = 1;
    @(negedge clk); ev_lcd_start = 0; cpu_wr = 0;
    rd(4'd0, rv); check("R8 set wins", rv & 16'h0002, 16'h0002);
    check("R8 other cleared", rv & 16'h0200, 16'h0000);

    // R9 map
    wr(4'd1, 16'hFFFF);
    rd(4'd1, rv); check("R9 enable mask", rv, 16'h0E7F);
    wr(4'd3, 16'hFFFF);
    rd(4'd3, rv); check("R9 ovf enable mask", rv, 16'h1FAE);
    wr(4'd5, 16'hFFFF);
    rd(4'd5, rv); check("R9 unmapped", rv, 16'h0000);

    // R10 reset mid-run
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    check("R10 irq after reset", {15'b0, irq_o}, 16'h0000);
    rd(4'd0, rv); check("R10 status after reset", rv, 16'h0000);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule